// File: doc/BRIEF.md
# Dataflow Loop Evaluator

This block evaluates a fixed four-iteration recurrence as a dataflow graph. For every iteration it forms a quotient `a = d / e`, a product `b = a * f` and a running sum `c = b + c_prev`, where the carry into the first iteration is zero. Each of the twelve graph nodes fires when all of its operands are valid. No program counter or static schedule decides when a node runs. A pool of identical processing elements executes the fired nodes. Each element handles any operator, uses a fixed latency per operator and holds one node at a time.

A caller presents the three input vectors together with a mode bit and uses a valid/ready handshake. `start_ready` is high only while the block is idle. An operand set is taken on the clock edge where `start_valid` and `start_ready` are both high. The caller may hold `start_valid` high for any number of cycles while the block is busy, and the payload is not sampled until the handshake completes. The result vectors are plain level outputs that update as nodes complete. `done` pulses when the final sum is written. `cycle_count` gives the length of the run.

A second mode limits evaluation to one processing element. The same node order then runs one operation at a time, which serves as a serial baseline for comparison with the overlapped schedule.

Top module: `dfg_loop_eval`

## Requirements
- R1: `start_ready` is 1 exactly when no run is in progress. An operand set is accepted only on an edge where `start_valid` and `start_ready` are both 1. While a run is in progress, `start_valid`, `serial_mode` and the data inputs have no effect on that run.
- R2: Iteration i (0-based) occupies bits `[16*i +: 16]` of every vector port. All arithmetic is unsigned 16-bit. `a_i = d_i / e_i` is truncating, `b_i` is the low 16 bits of `a_i * f_i`, and `c_i` is the low 16 bits of `b_i + c_(i-1)`, with `c_(-1) = 0`.
- R3: A quotient with a zero divisor is `16'hFFFF` and sets `div_err`. `div_err` stays 1 until the next accepted start, and the run still completes with all other results correct.
- R4: With `serial_mode = 0`, `done` is high in the cycle after the 9th rising edge following acceptance, and `cycle_count` then reads 9.
- R5: With `serial_mode = 1`, `done` is high after the 24th edge following acceptance, and `cycle_count` then reads 24.
- R6: `done` is a single-cycle pulse. Until the next accepted start, `cycle_count` holds its final value.
- R7: In parallel mode, all four quotients appear after edge 3 and none appears earlier. All four products appear after edge 5 and none appears earlier. Sum `c_i` appears after edge 6+i.
- R8: In serial mode, each iteration's quotient starts only after the previous iteration's sum is written. The quotient for iteration 1 therefore appears after edge 9 and not after edge 8.
- R9: After reset, `start_ready` = 1, `done` = 0, `div_err` = 0, `cycle_count` = 0 and all result vectors are 0.
- R10: An accepted start clears all result vectors, `cycle_count` and `div_err` on the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Operand set offered |
| start_ready | output | 1 | Block idle, operand set can be taken |
| serial_mode | input | 1 | 1 = one operation at a time, sampled with the operands |
| d_in | input | 64 | Dividends, 4 x 16 bits |
| e_in | input | 64 | Divisors, 4 x 16 bits |
| f_in | input | 64 | Multipliers, 4 x 16 bits |
| a_out | output | 64 | Quotients |
| b_out | output | 64 | Products |
| c_out | output | 64 | Running sums |
| done | output | 1 | One-cycle pulse when the last sum is written |
| cycle_count | output | 8 | Edges from acceptance to the last write, held afterwards |
| div_err | output | 1 | Sticky divide-by-zero flag for the current run |

## Verification
The bench traces a parallel run edge by edge. A design that passed results to dependent nodes one cycle early, or that kept an element busy for one extra cycle, would show quotients, products or sums at the wrong edge and report a count other than 9. In serial mode the bench checks the exact edge at which iteration 1's quotient appears. A scheduler that preferred operator type over iteration index would start all the divides first and miss that edge. The vector sweep covers products and sums that wrap, as well as zero divisors in the middle of the vector. It checks that the error flag is sticky, that it clears on the next start, and that a new start offered during a busy run is not taken.

// File: rtl/dfg_pkg.sv
package dfg_pkg;
  typedef enum logic [1:0] {
    OP_DIV = 2'd0,
    OP_MUL = 2'd1,
    OP_ADD = 2'd2
  } op_e;

  function automatic int max3(input int x, input int y, input int z);
    int m;
    m = (x > y) ? x : y;
    return (m > z) ? m : z;
  endfunction
endpackage

// File: rtl/dfg_pe.sv
module dfg_pe
  import dfg_pkg::*;
#(
  parameter int W       = 16,
  parameter int NW      = 4,
  parameter int LAT_DIV = 3,
  parameter int LAT_MUL = 2,
  parameter int LAT_ADD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_v,
  input  logic [NW-1:0] iss_node,
  input  op_e           iss_op,
  input  logic [W-1:0]  opnd_x,
  input  logic [W-1:0]  opnd_y,
  output logic          busy_o,
  output logic          wr_v,
  output logic [NW-1:0] wr_node,
  output logic [W-1:0]  wr_data,
  output logic          wr_dz
);
  localparam int LMAX = max3(LAT_DIV, LAT_MUL, LAT_ADD);
  localparam int LW   = $clog2(LMAX + 1);

  logic [LW-1:0]  lat;
  logic [W-1:0]   res_now;
  logic           dz_now;
  logic [2*W-1:0] prod;

  logic           busy_q;
  logic [LW-1:0]  rem_q;
  logic [NW-1:0]  node_q;
  logic [W-1:0]   res_q;
  logic           dz_q;

  always_comb begin
    prod    = {{W{1'b0}}, opnd_x} * {{W{1'b0}}, opnd_y};
    dz_now  = 1'b0;
    lat     = LW'(LAT_ADD);
    res_now = opnd_x + opnd_y;
    case (iss_op)
      OP_DIV: begin
        lat     = LW'(LAT_DIV);
        dz_now  = (opnd_y == '0);
        res_now = dz_now ? '1 : opnd_x / opnd_y;
      end
      OP_MUL: begin
        lat     = LW'(LAT_MUL);
        res_now = prod[W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      node_q <= '0;
      res_q  <= '0;
      dz_q   <= 1'b0;
    end else if (iss_v && (lat > LW'(1))) begin
      busy_q <= 1'b1;
      rem_q  <= lat - LW'(1);
      node_q <= iss_node;
      res_q  <= res_now;
      dz_q   <= dz_now;
    end else if (busy_q) begin
      if (rem_q == LW'(1)) busy_q <= 1'b0;
      rem_q <= rem_q - LW'(1);
    end
  end

  // A node completes at the edge ending its last execution cycle;
  // single-cycle operators complete at the edge they issue on.
  always_comb begin
    wr_v    = 1'b0;
    wr_node = node_q;
    wr_data = res_q;
    wr_dz   = dz_q;
    if (busy_q && (rem_q == LW'(1))) begin
      wr_v = 1'b1;
    end else if (iss_v && (lat == LW'(1))) begin
      wr_v    = 1'b1;
      wr_node = iss_node;
      wr_data = res_now;
      wr_dz   = dz_now;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/dfg_sched.sv
module dfg_sched #(
  parameter int NPE = 4,
  parameter int NN  = 12,
  parameter int NW  = 4
) (
  input  logic                    serial,
  input  logic [NPE-1:0]          pe_free,
  input  logic [NN-1:0]           ready,
  output logic [NPE-1:0]          iss_v,
  output logic [NPE-1:0][NW-1:0]  iss_node
);
  // Lowest node index wins; node index = 3*iteration + operator,
  // so iteration order dominates and divide < multiply < add inside it.
  logic [NN-1:0] claimed;

  always_comb begin
    claimed  = '0;
    iss_v    = '0;
    iss_node = '0;
    for (int p = 0; p < NPE; p++) begin
      if (pe_free[p] && (!serial || (p == 0))) begin
        for (int n = 0; n < NN; n++) begin
          if (!iss_v[p] && ready[n] && !claimed[n]) begin
            iss_v[p]    = 1'b1;
            iss_node[p] = NW'(n);
            claimed[n]  = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dfg_loop_eval.sv
module dfg_loop_eval
  import dfg_pkg::*;
#(
  parameter int W       = 16,
  parameter int NITER   = 4,
  parameter int NPE     = 4,
  parameter int LAT_DIV = 3,
  parameter int LAT_MUL = 2,
  parameter int LAT_ADD = 1,
  parameter int CW      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic             serial_mode,
  input  logic [NITER*W-1:0] d_in,
  input  logic [NITER*W-1:0] e_in,
  input  logic [NITER*W-1:0] f_in,
  output logic [NITER*W-1:0] a_out,
  output logic [NITER*W-1:0] b_out,
  output logic [NITER*W-1:0] c_out,
  output logic             done,
  output logic [CW-1:0]    cycle_count,
  output logic             div_err
);
  localparam int NN = 3 * NITER;
  localparam int NW = $clog2(NN);

  logic          run_q, mode_q, done_q, err_q;
  logic [CW-1:0] cnt_q;
  logic [NN-1:0] tok_q, fired_q, ready;
  logic [W-1:0]  d_q [NITER];
  logic [W-1:0]  e_q [NITER];
  logic [W-1:0]  f_q [NITER];
  logic [W-1:0]  a_q [NITER];
  logic [W-1:0]  b_q [NITER];
  logic [W-1:0]  c_q [NITER];
  logic [W-1:0]  cin [NITER];

  logic                   accept;
  logic [NPE-1:0]         pe_busy, pe_free, iss_v, wr_v, wr_dz;
  logic [NPE-1:0][NW-1:0] iss_node, wr_node;
  logic [NPE-1:0][W-1:0]  opx, opy, wr_data;
  op_e                    iss_op [NPE];
  int                     wr_it  [NPE];
  int                     wr_sel [NPE];
  logic                   last_wr;

  assign start_ready = !run_q;
  assign accept      = start_valid && start_ready;
  assign pe_free     = ~pe_busy;

  // Firing rule: a node is ready when unfired and all operand tokens exist.
  for (genvar i = 0; i < NITER; i++) begin : g_ready
    assign ready[3*i]   = run_q && !fired_q[3*i];
    assign ready[3*i+1] = run_q && !fired_q[3*i+1] && tok_q[3*i];
    if (i == 0) begin : g_first
      assign ready[3*i+2] = run_q && !fired_q[3*i+2] && tok_q[3*i+1];
      assign cin[i]       = '0;
    end else begin : g_rest
      assign ready[3*i+2] = run_q && !fired_q[3*i+2] && tok_q[3*i+1] && tok_q[3*i-1];
      assign cin[i]       = c_q[i-1];
    end
    assign a_out[i*W +: W] = a_q[i];
    assign b_out[i*W +: W] = b_q[i];
    assign c_out[i*W +: W] = c_q[i];
  end

  dfg_sched #(.NPE(NPE), .NN(NN), .NW(NW)) sched_i (
    .serial   (mode_q),
    .pe_free  (pe_free),
    .ready    (ready),
    .iss_v    (iss_v),
    .iss_node (iss_node)
  );

  for (genvar p = 0; p < NPE; p++) begin : g_pe
    int it_s, sel_s;

    always_comb begin
      it_s      = int'(iss_node[p]) / 3;
      sel_s     = int'(iss_node[p]) % 3;
      iss_op[p] = OP_ADD;
      opx[p]    = '0;
      opy[p]    = '0;
      if (it_s < NITER) begin
        case (sel_s)
          0: begin iss_op[p] = OP_DIV; opx[p] = d_q[it_s]; opy[p] = e_q[it_s]; end
          1: begin iss_op[p] = OP_MUL; opx[p] = a_q[it_s]; opy[p] = f_q[it_s]; end
          default: begin iss_op[p] = OP_ADD; opx[p] = b_q[it_s]; opy[p] = cin[it_s]; end
        endcase
      end
      wr_it[p]  = int'(wr_node[p]) / 3;
      wr_sel[p] = int'(wr_node[p]) % 3;
    end

    dfg_pe #(
      .W(W), .NW(NW), .LAT_DIV(LAT_DIV), .LAT_MUL(LAT_MUL), .LAT_ADD(LAT_ADD)
    ) pe_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .iss_v    (iss_v[p]),
      .iss_node (iss_node[p]),
      .iss_op   (iss_op[p]),
      .opnd_x   (opx[p]),
      .opnd_y   (opy[p]),
      .busy_o   (pe_busy[p]),
      .wr_v     (wr_v[p]),
      .wr_node  (wr_node[p]),
      .wr_data  (wr_data[p]),
      .wr_dz    (wr_dz[p])
    );
  end

  always_comb begin
    last_wr = 1'b0;
    for (int p = 0; p < NPE; p++)
      if (wr_v[p] && (wr_node[p] == NW'(NN - 1))) last_wr = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      tok_q   <= '0;
      fired_q <= '0;
      for (int i = 0; i < NITER; i++) begin
        d_q[i] <= '0; e_q[i] <= '0; f_q[i] <= '0;
        a_q[i] <= '0; b_q[i] <= '0; c_q[i] <= '0;
      end
    end else if (accept) begin
      run_q   <= 1'b1;
      mode_q  <= serial_mode;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      tok_q   <= '0;
      fired_q <= '0;
      for (int i = 0; i < NITER; i++) begin
        d_q[i] <= d_in[i*W +: W];
        e_q[i] <= e_in[i*W +: W];
        f_q[i] <= f_in[i*W +: W];
        a_q[i] <= '0; b_q[i] <= '0; c_q[i] <= '0;
      end
    end else begin
      done_q <= run_q && last_wr;
      if (run_q) begin
        cnt_q <= cnt_q + CW'(1);
        if (last_wr) run_q <= 1'b0;
      end
      for (int p = 0; p < NPE; p++) begin
        if (iss_v[p]) fired_q[iss_node[p]] <= 1'b1;
        if (wr_v[p]) begin
          tok_q[wr_node[p]] <= 1'b1;
          if (wr_dz[p]) err_q <= 1'b1;
          case (wr_sel[p])
            0:       a_q[wr_it[p]] <= wr_data[p];
            1:       b_q[wr_it[p]] <= wr_data[p];
            default: c_q[wr_it[p]] <= wr_data[p];
          endcase
        end
      end
    end
  end

  assign done        = done_q;
  assign cycle_count = cnt_q;
  assign div_err     = err_q;
endmodule

// File: rtl/dfg_loop_eval_chk.sv
module dfg_loop_eval_chk #(
  parameter int NITER   = 4,
  parameter int NPE     = 4,
  parameter int LAT_DIV = 3,
  parameter int LAT_MUL = 2,
  parameter int LAT_ADD = 1,
  parameter int CW      = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_valid,
  input logic          start_ready,
  input logic          done,
  input logic [CW-1:0] cycle_count,
  input logic          div_err,
  input logic          serial
);
  localparam int PAR_CYC = LAT_DIV + LAT_MUL + NITER * LAT_ADD;
  localparam int SER_CYC = NITER * (LAT_DIV + LAT_MUL + LAT_ADD);

  AST_READY_DROP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_ready) |-> $past(start_valid)); // R1
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> start_ready); // R1
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (div_err && !(start_valid && start_ready)) |=> div_err); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ready && !start_valid) |=> $stable(cycle_count)); // R6
  AST_SERIAL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && serial) |-> (cycle_count == CW'(SER_CYC))); // R5

  if (NITER <= NPE) begin : g_par
    AST_PARALLEL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !serial) |-> (cycle_count == CW'(PAR_CYC))); // R4
  end
endmodule

bind dfg_loop_eval dfg_loop_eval_chk #(
  .NITER(NITER), .NPE(NPE), .LAT_DIV(LAT_DIV), .LAT_MUL(LAT_MUL),
  .LAT_ADD(LAT_ADD), .CW(CW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .done        (done),
  .cycle_count (cycle_count),
  .div_err     (div_err),
  .serial      (mode_q)
);

// File: tb/dfg_loop_eval_tb_top.sv
`timescale 1ns/1ps
module dfg_loop_eval_tb_top;
  localparam int W = 16;
  localparam int N = 4;
  localparam int VW = N * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic          serial_mode = 1'b0;
  logic [VW-1:0] d_in = '0, e_in = '0, f_in = '0;
  logic [VW-1:0] a_out, b_out, c_out;
  logic          done;
  logic [7:0]    cycle_count;
  logic          div_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dfg_loop_eval dut_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .serial_mode(serial_mode), .d_in(d_in), .e_in(e_in), .f_in(f_in),
    .a_out(a_out), .b_out(b_out), .c_out(c_out), .done(done),
    .cycle_count(cycle_count), .div_err(div_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [VW-1:0] d, e, f,
                       output logic [VW-1:0] a, b, c, output logic err);
    logic [W-1:0] run_c, qa, pb;
    logic [2*W-1:0] pr;
    run_c = '0; err = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (e[i*W +: W] == '0) begin qa = '1; err = 1'b1; end
      else qa = d[i*W +: W] / e[i*W +: W];
      pr = {{W{1'b0}}, qa} * {{W{1'b0}}, f[i*W +: W]};
      pb = pr[W-1:0];
      run_c = pb + run_c;
      a[i*W +: W] = qa; b[i*W +: W] = pb; c[i*W +: W] = run_c;
    end
  endtask

  task automatic launch(input bit mode, input logic [VW-1:0] d, e, f);
    @(negedge clk);
    start_valid = 1'b1; serial_mode = mode; d_in = d; e_in = e; f_in = f;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] d, e, f, ea, eb, ec, pc;
    logic          eerr;
    int            edges;

    // R9 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "ready", VW'(start_ready), VW'(1));
    chk("R9", "done", VW'(done), VW'(0));
    chk("R9", "div_err", VW'(div_err), VW'(0));
    chk("R9", "count", VW'(cycle_count), VW'(0));
    chk("R9", "results", a_out | b_out | c_out, '0);

    // R7 / R1 edge-by-edge parallel trace
    d = {16'd400, 16'd300, 16'd200, 16'd100};
    e = {16'd9, 16'd7, 16'd5, 16'd3};
    f = {16'd5, 16'd4, 16'd3, 16'd2};
    model(d, e, f, ea, eb, ec, eerr);
    launch(1'b0, d, e, f);
    chk("R1", "ready busy", VW'(start_ready), VW'(0));
    for (int k = 1; k <= 9; k++) begin
      step();
      chk("R7", $sformatf("a edge %0d", k), a_out, (k >= 3) ? ea : '0);
      chk("R7", $sformatf("b edge %0d", k), b_out, (k >= 5) ? eb : '0);
      pc = '0;
      for (int i = 0; i < N; i++) if (k >= 6 + i) pc[i*W +: W] = ec[i*W +: W];
      chk("R7", $sformatf("c edge %0d", k), c_out, pc);
      chk("R1", $sformatf("ready edge %0d", k), VW'(start_ready), VW'(k == 9));
      chk("R4", $sformatf("done edge %0d", k), VW'(done), VW'(k == 9));
      if (k == 4) begin
        start_valid = 1'b1; serial_mode = 1'b1; d_in = '1; e_in = '0; f_in = '1;
      end
      if (k == 6) start_valid = 1'b0;
    end
    chk("R1", "no err from ignored start", VW'(div_err), VW'(0));
    chk("R4", "count", VW'(cycle_count), VW'(9));
    step();
    chk("R6", "done pulse low", VW'(done), VW'(0));
    repeat (5) step();
    chk("R6", "count held", VW'(cycle_count), VW'(9));
    chk("R1", "results kept", c_out, ec);

    // R2 / R3 / R4 / R5 sweep over vector patterns and both modes
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 8; k++) begin
        for (int i = 0; i < N; i++) begin
          d[i*W +: W] = W'(k * 4099 + i * 1013 + 77);
          e[i*W +: W] = W'(k * 3 + i + 1);
          f[i*W +: W] = W'(k * 911 + i * 57 + 1);
        end
        if (k == 3 || k == 7) e[2*W +: W] = '0;
        if (k == 5) begin d = '1; e[W-1:0] = W'(1); f = '1; end
        model(d, e, f, ea, eb, ec, eerr);
        launch(m[0], d, e, f);
        edges = 1;
        step();
        while (!done && edges < 100) begin step(); edges++; end
        chk(m ? "R5" : "R4", "latency", VW'(edges), VW'(m ? 24 : 9));
        chk(m ? "R5" : "R4", "count", VW'(cycle_count), VW'(m ? 24 : 9));
        chk("R2", "a", a_out, ea);
        chk("R2", "b", b_out, eb);
        chk("R2", "c", c_out, ec);
        chk("R3", "div_err", VW'(div_err), VW'(eerr));
        step();
        chk("R3", "div_err sticky", VW'(div_err), VW'(eerr));
      end
    end

    // R10 clear on start, then R8 serial ordering
    d = {16'd80, 16'd60, 16'd40, 16'd20};
    e = {16'd4, 16'd3, 16'd2, 16'd1};
    f = {16'd1, 16'd2, 16'd3, 16'd4};
    model(d, e, f, ea, eb, ec, eerr);
    launch(1'b1, d, e, f);
    chk("R10", "err cleared", VW'(div_err), VW'(0));
    chk("R10", "count cleared", VW'(cycle_count), VW'(0));
    chk("R10", "results cleared", a_out | b_out | c_out, '0);
    for (int k = 1; k <= 9; k++) begin
      step();
      if (k == 8) chk("R8", "a1 before edge 9", VW'(a_out[W +: W]), VW'(0));
      if (k == 9) chk("R8", "a1 at edge 9", VW'(a_out[W +: W]), VW'(ea[W +: W]));
      if (k == 6) chk("R8", "c0 at edge 6", VW'(c_out[W-1:0]), VW'(ec[W-1:0]));
    end
    edges = 9;
    while (!done && edges < 100) begin step(); edges++; end
    chk("R5", "serial latency", VW'(edges), VW'(24));
    chk("R2", "serial c", c_out, ec);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule